// File: doc/BRIEF.md
# Streaming Momentum-Form Motion Integrator

This block performs the motion-integration phase of a particle simulation in fixed point. After a start pulse it sweeps a programmable number of particles, issuing one read per cycle to external synchronous particle memories. For each particle it receives position, velocity and accumulated force, plus a small type code. The stored velocity is treated as momentum and the stored acceleration as raw force, so mass enters only here: a per-type reciprocal-mass value, held in a small internal table, scales the force-times-step impulse before it is added to the velocity.

The updated velocity and position leave an eight-stage pipeline one per cycle, tagged with the particle's address so they can be written back in place. Particles are independent in this phase, so the pipeline never stalls and results stream back to back. The time step is sampled when a sweep starts. A done flag rises once the last result has been written.

Top module: `motion_update_unit`

## Requirements
- R1: During and after reset, `rd_en`, `wr_en` and `done` are low until a sweep is started.
- R2: A `start` pulse seen while idle with `part_count` = N > 0 produces exactly N read requests on consecutive cycles with `rd_addr` = 0, 1, ..., N-1 in ascending order.
- R3: The memories answer one cycle after `rd_en`. Each `wr_en` appears exactly 9 cycles after the `rd_en` of the same particle: one memory cycle plus eight pipeline stages. `wr_addr` equals that particle's `rd_addr`, and results leave in issue order, one per cycle.
- R4: All data are signed two's complement, DATA_W bits, with FRAC_W fractional bits. A fixed-point product is the full signed product shifted arithmetically right by FRAC_W and truncated to DATA_W bits, and sums wrap modulo 2^DATA_W. The new velocity is vel + fx(fx(force, dt), rmass[type]).
- R5: The new position is pos + fx(dt, new velocity). It uses the updated velocity, not the old one.
- R6: The reciprocal mass is read from a table of 2^TYPE_W entries indexed by `rd_type`. An entry is loaded with `rm_we`, `rm_addr` and `rm_data`, and particles that differ only in type receive that type's entry.
- R7: `done` is cleared by an accepted start and rises in the cycle after the last `wr_en`. It then stays high until the next accepted start. With `part_count` = 0 it rises in the second cycle after the start edge, and no read or write occurs.
- R8: A `start` seen while a sweep is running has no effect, and `step_in` is sampled only at an accepted start. The running sweep keeps its original count and time step, and no extra writes follow it.
- R9: A full sweep of `part_count` = 2^ADDR_W particles is supported and writes every address exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sweep (accepted only while idle) |
| part_count | input | ADDR_W+1 | Number of particles in the sweep |
| step_in | input | DATA_W | Time step, fixed point |
| rm_we | input | 1 | Reciprocal-mass table write enable |
| rm_addr | input | TYPE_W | Table entry (particle type) to write |
| rm_data | input | DATA_W | Reciprocal mass, fixed point |
| rd_en | output | 1 | Read request to particle memories |
| rd_addr | output | ADDR_W | Particle address to read |
| rd_pos | input | DATA_W | Position returned one cycle after request |
| rd_vel | input | DATA_W | Velocity (momentum) returned |
| rd_frc | input | DATA_W | Accumulated force returned |
| rd_type | input | TYPE_W | Particle type returned |
| wr_en | output | 1 | Write-back strobe |
| wr_addr | output | ADDR_W | Address of the result |
| wr_pos | output | DATA_W | Updated position |
| wr_vel | output | DATA_W | Updated velocity (momentum) |
| done | output | 1 | Sweep finished, sticky until next start |

## Verification
A misaligned stage register shows up as a write whose address does not match the value it carries, or as a latency other than 9 cycles, on the first particle of a sweep. A wrong table entry or scaling shows as wrong velocities, and then wrong positions, in the same cycle that particle is written. A fault in the sweep counter shows as a missing, duplicated or out-of-order `wr_addr`, or as `done` rising off by a cycle. Random data over many counts and time steps, together with equal-data particles of different types, expose a miswired operand within one sweep.

// File: rtl/mu_pkg.sv
package mu_pkg;
  typedef enum logic {SW_IDLE, SW_RUN} sweep_state_t;
  localparam int PIPE_STAGES = 8;
  localparam int DEF_DATA_W = 32;
  localparam int DEF_FRAC_W = 16;
  localparam int DEF_ADDR_W = 10;
  localparam int DEF_TYPE_W = 2;
endpackage

// File: rtl/mu_sweep_ctrl.sv
module mu_sweep_ctrl
  import mu_pkg::*;
#(
  parameter int DATA_W = DEF_DATA_W,
  parameter int ADDR_W = DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W:0]   part_count,
  input  logic [DATA_W-1:0] step_in,
  input  logic              inflight,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] dt_q,
  output logic              done
);
  sweep_state_t      st;
  logic [ADDR_W:0]   left_q;
  logic [ADDR_W-1:0] next_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SW_IDLE;
      left_q  <= '0;
      next_q  <= '0;
      rd_en   <= 1'b0;
      rd_addr <= '0;
      dt_q    <= '0;
      done    <= 1'b0;
    end else begin
      case (st)
        SW_IDLE: begin
          rd_en <= 1'b0;
          if (start) begin
            st     <= SW_RUN;
            left_q <= part_count;
            next_q <= '0;
            dt_q   <= step_in;
            done   <= 1'b0;
          end
        end
        default: begin
          if (left_q != '0) begin
            rd_en   <= 1'b1;
            rd_addr <= next_q;
            next_q  <= next_q + 1'b1;
            left_q  <= left_q - 1'b1;
          end else begin
            rd_en <= 1'b0;
            if (!rd_en && !inflight) begin
              st   <= SW_IDLE;
              done <= 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/mu_inv_mass_table.sv
module mu_inv_mass_table
  import mu_pkg::*;
#(
  parameter int DATA_W = DEF_DATA_W,
  parameter int TYPE_W = DEF_TYPE_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [TYPE_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [TYPE_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << TYPE_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mu_integrate_pipe.sv
module mu_integrate_pipe
  import mu_pkg::*;
#(
  parameter int DATA_W = DEF_DATA_W,
  parameter int FRAC_W = DEF_FRAC_W,
  parameter int ADDR_W = DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_pos,
  input  logic [DATA_W-1:0] rd_vel,
  input  logic [DATA_W-1:0] rd_frc,
  input  logic [DATA_W-1:0] rmass,
  input  logic [DATA_W-1:0] dt,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_pos,
  output logic [DATA_W-1:0] wr_vel,
  output logic              inflight
);
  localparam int NS = PIPE_STAGES;
  localparam int PW = 2 * DATA_W;

  typedef logic signed [DATA_W-1:0] word_t;

  function automatic word_t fx_mul(input word_t a, input word_t b);
    logic signed [PW-1:0] p;
    p = a * b;
    return p[FRAC_W+DATA_W-1:FRAC_W];
  endfunction

  // valid and address travel alongside the data; index 0 is the memory cycle
  logic [NS:0]       vld;
  logic [ADDR_W-1:0] adr [NS+1];

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else     vld <= {vld[NS-1:0], rd_en};
  end

  always_ff @(posedge clk) adr[0] <= rd_addr;

  for (genvar i = 1; i <= NS; i++) begin : g_adr
    always_ff @(posedge clk) adr[i] <= adr[i-1];
  end

  assign inflight = |vld[NS-1:0];
  assign wr_en    = vld[NS];
  assign wr_addr  = adr[NS];

  word_t pos1, vel1, frc1;
  word_t pos2, vel2, fdt2, rm2;
  word_t pos3, vel3, imp3;
  word_t pos4, vn4;
  word_t pos5, vn5;
  logic signed [PW-1:0] prod5;
  word_t pos6, vn6, dq6;
  word_t vn7, pn7;

  always_ff @(posedge clk) begin
    // S1: capture memory data; table output aligns with this stage
    pos1  <= rd_pos;
    vel1  <= rd_vel;
    frc1  <= rd_frc;
    // S2: force times step
    pos2  <= pos1;
    vel2  <= vel1;
    fdt2  <= fx_mul(frc1, dt);
    rm2   <= rmass;
    // S3: impulse scaled by reciprocal mass
    pos3  <= pos2;
    vel3  <= vel2;
    imp3  <= fx_mul(fdt2, rm2);
    // S4: new momentum
    pos4  <= pos3;
    vn4   <= vel3 + imp3;
    // S5: full-width step times new velocity
    pos5  <= pos4;
    vn5   <= vn4;
    prod5 <= $signed(dt) * vn4;
    // S6: rescale displacement
    pos6  <= pos5;
    vn6   <= vn5;
    dq6   <= prod5[FRAC_W+DATA_W-1:FRAC_W];
    // S7: new position
    vn7   <= vn6;
    pn7   <= pos6 + dq6;
    // S8: registered outputs
    wr_pos <= pn7;
    wr_vel <= vn7;
  end
endmodule

// File: rtl/motion_update_unit.sv
module motion_update_unit
  import mu_pkg::*;
#(
  parameter int DATA_W = DEF_DATA_W,
  parameter int FRAC_W = DEF_FRAC_W,
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int TYPE_W = DEF_TYPE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W:0]   part_count,
  input  logic [DATA_W-1:0] step_in,
  input  logic              rm_we,
  input  logic [TYPE_W-1:0] rm_addr,
  input  logic [DATA_W-1:0] rm_data,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_pos,
  input  logic [DATA_W-1:0] rd_vel,
  input  logic [DATA_W-1:0] rd_frc,
  input  logic [TYPE_W-1:0] rd_type,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_pos,
  output logic [DATA_W-1:0] wr_vel,
  output logic              done
);
  logic [DATA_W-1:0] dt_q;
  logic [DATA_W-1:0] rmass;
  logic              inflight;

  mu_sweep_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .part_count(part_count),
    .step_in(step_in), .inflight(inflight), .rd_en(rd_en),
    .rd_addr(rd_addr), .dt_q(dt_q), .done(done)
  );

  mu_inv_mass_table #(.DATA_W(DATA_W), .TYPE_W(TYPE_W)) u_rmass (
    .clk(clk), .we(rm_we), .waddr(rm_addr), .wdata(rm_data),
    .raddr(rd_type), .rdata(rmass)
  );

  mu_integrate_pipe #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .ADDR_W(ADDR_W)) u_pipe (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_pos(rd_pos), .rd_vel(rd_vel), .rd_frc(rd_frc), .rmass(rmass),
    .dt(dt_q), .wr_en(wr_en), .wr_addr(wr_addr), .wr_pos(wr_pos),
    .wr_vel(wr_vel), .inflight(inflight)
  );
endmodule

// File: rtl/mu_checker.sv
module mu_checker #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              done
);
  logic [3:0] seen;
  always_ff @(posedge clk) begin
    if (rst)             seen <= '0;
    else if (seen != 4'd9) seen <= seen + 4'd1;
  end

  // R3
  wr_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (seen == 4'd9 && wr_en) |-> ($past(rd_en, 9) && wr_addr == $past(rd_addr, 9)));

  // R2
  rd_ascend_chk: assert property (@(posedge clk) disable iff (rst)
    (seen != 4'd0 && rd_en && $past(rd_en)) |-> (rd_addr == ADDR_W'($past(rd_addr) + 1'b1)));

  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!rd_en && !wr_en));

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);
endmodule

bind motion_update_unit mu_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .rd_en(rd_en), .rd_addr(rd_addr),
  .wr_en(wr_en), .wr_addr(wr_addr), .done(done)
);

// File: tb/sim_motion_update_unit.sv
module sim_motion_update_unit;
  localparam int W  = 32;
  localparam int F  = 16;
  localparam int AW = 10;
  localparam int TW = 2;
  localparam int NP = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [AW:0] part_count = '0;
  logic [W-1:0] step_in = '0;
  logic rm_we = 1'b0;
  logic [TW-1:0] rm_addr = '0;
  logic [W-1:0] rm_data = '0;
  logic rd_en, wr_en, done;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [W-1:0] rd_pos, rd_vel, rd_frc, wr_pos, wr_vel;
  logic [TW-1:0] rd_type;

  always #2 clk = ~clk;

  motion_update_unit #(.DATA_W(W), .FRAC_W(F), .ADDR_W(AW), .TYPE_W(TW)) u0 (
    .clk(clk), .rst(rst), .start(start), .part_count(part_count),
    .step_in(step_in), .rm_we(rm_we), .rm_addr(rm_addr), .rm_data(rm_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_pos(rd_pos), .rd_vel(rd_vel),
    .rd_frc(rd_frc), .rd_type(rd_type), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_pos(wr_pos), .wr_vel(wr_vel), .done(done)
  );

  logic signed [W-1:0] m_pos [NP];
  logic signed [W-1:0] m_vel [NP];
  logic signed [W-1:0] m_frc [NP];
  logic [TW-1:0]       m_typ [NP];
  logic signed [W-1:0] o_pos [NP];
  logic signed [W-1:0] o_vel [NP];
  logic signed [W-1:0] rm_tab [1<<TW];
  int rd_cyc [NP];

  int nchk = 0, nfail = 0;
  int cyc = 0, n_wr = 0, last_wr = 0, done_cyc = 0;
  logic done_prev = 1'b0;

  // synchronous particle memory model
  always @(posedge clk) begin
    if (rd_en) begin
      rd_pos  <= m_pos[rd_addr];
      rd_vel  <= m_vel[rd_addr];
      rd_frc  <= m_frc[rd_addr];
      rd_type <= m_typ[rd_addr];
    end
  end

  function automatic void chk(input bit ok, input string req, input string what,
                              input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endfunction

  function automatic logic signed [W-1:0] fxm(input logic signed [W-1:0] a,
                                                input logic signed [W-1:0] b);
    longint p;
    p = longint'(a) * longint'(b);
    p = p >>> F;
    return p[W-1:0];
  endfunction

  function automatic logic signed [W-1:0] exp_vel(input int i, input logic signed [W-1:0] dt);
    return m_vel[i] + fxm(fxm(m_frc[i], dt), rm_tab[m_typ[i]]);
  endfunction

  function automatic logic signed [W-1:0] exp_pos(input int i, input logic signed [W-1:0] dt);
    return m_pos[i] + fxm(dt, exp_vel(i, dt));
  endfunction

  // monitor, sampled away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rd_en) rd_cyc[rd_addr] = cyc;
    if (wr_en) begin
      chk(wr_addr == AW'(n_wr), "R3", "write order addr", longint'(wr_addr), longint'(n_wr));
      chk(cyc - rd_cyc[wr_addr] == 9, "R3", "read-to-write latency",
          longint'(cyc - rd_cyc[wr_addr]), 9);
      o_pos[wr_addr] = wr_pos;
      o_vel[wr_addr] = wr_vel;
      n_wr++;
      last_wr = cyc;
    end
    if (done && !done_prev) done_cyc = cyc;
    done_prev = done;
    if (cyc > 150000) begin
      nfail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  task automatic load_rm(input int t, input logic signed [W-1:0] v);
    @(negedge clk);
    rm_we = 1'b1; rm_addr = TW'(t); rm_data = v;
    @(negedge clk);
    rm_we = 1'b0;
    rm_tab[t] = v;
  endtask

  function automatic int srnd(input int r);
    return int'($urandom_range(0, 2 * r)) - r;
  endfunction

  task automatic fill_rand(input int n);
    for (int i = 0; i < n; i++) begin
      m_pos[i] = srnd(1 << 24);
      m_vel[i] = srnd(1 << 20);
      m_frc[i] = srnd(1 << 22);
      m_typ[i] = TW'($urandom_range(0, (1 << TW) - 1));
    end
  endtask

  task automatic run_sweep(input int n, input logic signed [W-1:0] dtv, input bit poke,
                           input string req);
    n_wr = 0;
    @(negedge clk);
    start = 1'b1; part_count = (AW+1)'(n); step_in = dtv;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R7", "done cleared by start", longint'(done), 0);
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1; part_count = (AW+1)'(n + 7); step_in = dtv + 32'sd999;
      @(negedge clk);
      start = 1'b0;
    end
    for (int g = 0; g < 3000 && !done; g++) @(negedge clk);
    repeat (12) @(negedge clk);
    chk(n_wr == n, req, "write count", longint'(n_wr), longint'(n));
    chk(done == 1'b1, "R7", "done held high", longint'(done), 1);
    if (n > 0)
      chk(done_cyc == last_wr + 1, "R7", "done one cycle after last write",
          longint'(done_cyc), longint'(last_wr + 1));
    for (int i = 0; i < n; i++) begin
      chk(o_vel[i] == exp_vel(i, dtv), req == "R8" ? "R8" : "R4", "new velocity",
          longint'(o_vel[i]), longint'(exp_vel(i, dtv)));
      chk(o_pos[i] == exp_pos(i, dtv), req == "R8" ? "R8" : "R5", "new position",
          longint'(o_pos[i]), longint'(exp_pos(i, dtv)));
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(rd_en == 1'b0, "R1", "rd_en after reset", longint'(rd_en), 0);
    chk(wr_en == 1'b0, "R1", "wr_en after reset", longint'(wr_en), 0);
    chk(done == 1'b0, "R1", "done after reset", longint'(done), 0);

    // R6: table entries per type
    load_rm(0, 32'sd65536);
    load_rm(1, 32'sd32768);
    load_rm(2, 32'sd131072);
    load_rm(3, 32'sd21845);

    // R6: equal data, different types
    for (int i = 0; i < 4; i++) begin
      m_pos[i] = 32'sd100000; m_vel[i] = 32'sd40000; m_frc[i] = -32'sd300000;
      m_typ[i] = TW'(i);
    end
    // R5: zero force keeps velocity, position moves by dt*vel
    m_pos[4] = -32'sd5000000; m_vel[4] = 32'sd777777; m_frc[4] = 32'sd0; m_typ[4] = 2'd1;
    m_pos[5] = 32'sd0; m_vel[5] = -32'sd123456; m_frc[5] = 32'sd4000000; m_typ[5] = 2'd3;
    run_sweep(6, 32'sd65536, 1'b0, "R2");
    chk(o_vel[0] != o_vel[1] && o_vel[1] != o_vel[2], "R6", "type selects rmass",
        longint'(o_vel[1]), longint'(exp_vel(1, 32'sd65536)));
    chk(o_vel[4] == m_vel[4], "R5", "zero force velocity kept",
        longint'(o_vel[4]), longint'(m_vel[4]));

    // random sweeps, R2 R3 R4 R5
    for (int k = 0; k < 6; k++) begin
      int n = int'($urandom_range(1, 60));
      logic signed [W-1:0] dtv = W'($urandom_range(1, 8000));
      fill_rand(n);
      run_sweep(n, dtv, 1'b0, "R2");
    end

    // R7: zero count
    n_wr = 0;
    @(negedge clk);
    start = 1'b1; part_count = '0; step_in = 32'sd100;
    @(negedge clk);
    start = 1'b0;
    chk(rd_en == 1'b0, "R7", "no read for zero count", longint'(rd_en), 0);
    @(negedge clk);
    chk(done == 1'b1, "R7", "zero count done in second cycle", longint'(done), 1);
    repeat (12) @(negedge clk);
    chk(n_wr == 0, "R7", "no write for zero count", longint'(n_wr), 0);

    // R8: start and new step during a sweep are ignored
    fill_rand(40);
    run_sweep(40, 32'sd3000, 1'b1, "R8");

    // R9: full capacity
    fill_rand(NP);
    run_sweep(NP, 32'sd1500, 1'b0, "R9");

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule